// File: doc/BRIEF.md
# Burst Memory Responder

This block stands in for a memory controller and its memory as seen from the user side of that controller. A requester issues write bursts and read bursts with a word address, a burst length of one or two beats, a start-of-burst strobe and per-byte write enables. Words are kept in an on-chip array. Read data comes back after a fixed latency, and a one-cycle valid strobe marks each returned word.

The responder lowers its ready output in pseudo-random cycles. A requester therefore has to keep its command, address and data steady until ready is seen high. After reset, an initialisation flag stays low for a fixed number of cycles, and nothing is accepted until it rises. The internal word width is the device data width times a rate factor: 2 for a full-rate controller and 4 for a half-rate one.

Top module: `burst_mem_responder`

## Requirements
- R1: After reset `init_done` is low. It rises after exactly INIT_CYCLES rising clock edges and then stays high. While it is low, `ready` is low and every request is ignored.
- R2: A write beat is taken only in a cycle where `ready` and `wr_req` are high and `rd_req` is low. When no burst is open, a taken beat with `burst_begin` high starts a burst at `addr`. A `size` value of 2 makes a two-beat burst, and any other value makes a one-beat burst.
- R3: Beat 1 of a two-beat write burst starting at A goes to A+1, taken modulo the array depth. On that beat `addr` and `burst_begin` are ignored, and the requester may leave idle cycles before it.
- R4: Byte lane i of a write, bits 8i+7 down to 8i, changes only when `be[i]` is 1.
- R5: A read is taken in a cycle where `ready` and `rd_req` are high, `wr_req` is low and no write burst is open. `rdata_valid` then goes high exactly RD_LAT cycles later with the word at A. For size 2 it is also high in the following cycle with the word at A+1. It is never high at any other time.
- R6: In the cycle after a two-beat read is taken, `ready` is low.
- R7: Single-beat reads can be taken on consecutive ready cycles, with up to RD_LAT reads in flight. Their results come back in request order.
- R8: After `init_done`, a cycle with both `rd_req` and `wr_req` high takes neither request. It raises `proto_err` for one cycle in the next cycle.
- R9: While a write burst is open, read requests are not taken and produce no read data.
- R10: When no burst is open, a write beat with `burst_begin` low is ignored.
- R11: With STALL_EN set, a 16-bit LFSR drops `ready` in some cycles after `init_done`, even with no read in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_done | output | 1 | Startup delay over, requests may be issued |
| ready | output | 1 | A request or write beat is taken in this cycle if presented |
| wr_req | input | 1 | Write beat request |
| rd_req | input | 1 | Read request |
| burst_begin | input | 1 | First beat of a burst |
| addr | input | ADDR_W | Word address |
| size | input | 2 | Burst length in beats (2 means two beats) |
| wdata | input | DEV_W*RATE | Write word |
| be | input | DEV_W*RATE/8 | Byte write enables |
| rdata | output | DEV_W*RATE | Read word |
| rdata_valid | output | 1 | Read word valid, one cycle per beat |
| proto_err | output | 1 | Read and write were requested in the same cycle |

## Verification
A wrong open-burst flag or a wrong second-beat address does not show up when the write happens. It shows up later, when a read of the affected word returns the wrong data exactly RD_LAT cycles after that read is taken. A slip in the read pipeline shows up at once as a valid strobe in the wrong cycle. The same holds for a missing one-cycle ready gap after a two-beat read. A fault in the init counter or in the error flag appears in the very cycle it happens, because the model predicts both outputs for every cycle.

// File: rtl/burst_mem_responder.sv
module burst_mem_responder #(
  parameter int DEV_W       = 16,
  parameter int RATE        = 2,
  parameter int ADDR_W      = 6,
  parameter int RD_LAT      = 4,
  parameter int INIT_CYCLES = 16,
  parameter bit STALL_EN    = 1'b1,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic                       init_done,
  output logic                       ready,
  input  logic                       wr_req,
  input  logic                       rd_req,
  input  logic                       burst_begin,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [1:0]                 size,
  input  logic [DEV_W*RATE-1:0]      wdata,
  input  logic [DEV_W*RATE/8-1:0]    be,
  output logic [DEV_W*RATE-1:0]      rdata,
  output logic                       rdata_valid,
  output logic                       proto_err
);
  localparam int WORD_W = DEV_W * RATE;
  localparam int BE_W   = WORD_W / 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(INIT_CYCLES + 1);

  logic [CNT_W-1:0]  init_cnt;
  logic [15:0]       lfsr;
  logic              wr_open;
  logic [ADDR_W-1:0] wr_next;
  logic              rd_pend;
  logic [ADDR_W-1:0] rd_pend_addr;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [RD_LAT-1:0] pv;
  logic [WORD_W-1:0] pd [RD_LAT];

  wire stall  = STALL_EN && (lfsr[1:0] == 2'b00);
  assign ready = init_done && !stall && !rd_pend;

  wire two     = (size == 2'd2);
  wire wr_acc  = ready && wr_req && !rd_req;
  wire wr_beat = wr_acc && (wr_open || burst_begin);
  wire [ADDR_W-1:0] wr_addr = wr_open ? wr_next : addr;
  wire rd_acc  = ready && rd_req && !wr_req && !wr_open;
  wire ins_v   = rd_acc || rd_pend;
  wire [ADDR_W-1:0] ins_a = rd_pend ? rd_pend_addr : addr;

  assign rdata_valid = pv[RD_LAT-1];
  assign rdata       = pd[RD_LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt  <= '0;
      init_done <= 1'b0;
    end else if (!init_done) begin
      init_cnt  <= init_cnt + CNT_W'(1);
      init_done <= (init_cnt == CNT_W'(INIT_CYCLES - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= LFSR_SEED;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_open <= 1'b0;
      wr_next <= '0;
    end else if (wr_beat) begin
      if (wr_open) begin
        wr_open <= 1'b0;
      end else if (two) begin
        wr_open <= 1'b1;
        wr_next <= addr + ADDR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_beat)
      for (int b = 0; b < BE_W; b++)
        if (be[b]) mem[wr_addr][8*b +: 8] <= wdata[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend      <= 1'b0;
      rd_pend_addr <= '0;
      pv           <= '0;
      proto_err    <= 1'b0;
    end else begin
      rd_pend   <= rd_acc && two;
      if (rd_acc) rd_pend_addr <= addr + ADDR_W'(1);
      pv        <= {pv[RD_LAT-2:0], ins_v};
      proto_err <= init_done && rd_req && wr_req;
    end
  end

  always_ff @(posedge clk) begin
    pd[0] <= mem[ins_a];
    for (int i = 1; i < RD_LAT; i++) pd[i] <= pd[i-1];
  end
endmodule

module burst_mem_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_done,
  input logic       ready,
  input logic       wr_req,
  input logic       rd_req,
  input logic [1:0] size,
  input logic       proto_err,
  input logic       rdata_valid,
  input logic       wr_open
);
  assert_ready_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ready);
  assert_init_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  assert_no_early_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !rdata_valid);
  assert_read_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rd_req && !wr_req && !wr_open && size == 2'd2) |=> !ready);
  assert_err_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && rd_req && wr_req) |=> proto_err);
  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(rd_req && wr_req));
endmodule

bind burst_mem_responder burst_mem_responder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .init_done(init_done), .ready(ready),
  .wr_req(wr_req), .rd_req(rd_req), .size(size), .proto_err(proto_err),
  .rdata_valid(rdata_valid), .wr_open(wr_open)
);

// File: tb/burst_mem_responder_tb.sv
module burst_mem_responder_tb_top;
  localparam int DEV_W = 16, RATE = 2, ADDR_W = 6, RD_LAT = 4, INIT_CYCLES = 16;
  localparam int WORD_W = DEV_W * RATE, BE_W = WORD_W / 8, DEPTH = 1 << ADDR_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, init_done, ready, wr_req, rd_req, burst_begin, rdata_valid, proto_err;
  logic [ADDR_W-1:0] addr;
  logic [1:0] size;
  logic [WORD_W-1:0] wdata, rdata;
  logic [BE_W-1:0] be;

  burst_mem_responder #(.DEV_W(DEV_W), .RATE(RATE), .ADDR_W(ADDR_W), .RD_LAT(RD_LAT),
    .INIT_CYCLES(INIT_CYCLES)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .ready(ready), .wr_req(wr_req),
    .rd_req(rd_req), .burst_begin(burst_begin), .addr(addr), .size(size), .wdata(wdata),
    .be(be), .rdata(rdata), .rdata_valid(rdata_valid), .proto_err(proto_err));

  int n_run = 0, n_fail = 0, cyc = 0, pcount = 0;
  logic [WORD_W-1:0] mm [DEPTH];
  bit m_open = 0, exp_err = 0, prev_gap = 0, saw_stall = 0, finished = 0;
  logic [ADDR_W-1:0] m_next;
  int q_due[$];
  logic [WORD_W-1:0] q_dat[$];
  string q_tag[$];
  string cur_tag = "R5";

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic merge(logic [ADDR_W-1:0] a);
    for (int b = 0; b < BE_W; b++)
      if (be[b]) mm[a][8*b +: 8] = wdata[8*b +: 8];
  endtask

  always @(posedge clk) if (rst_n) pcount++;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    chk(init_done === (pcount >= INIT_CYCLES), "R1", "init_done", init_done, pcount >= INIT_CYCLES);
    if (!init_done) chk(ready === 1'b0, "R1", "ready before init", ready, 0);
    if (prev_gap) chk(ready === 1'b0, "R6", "ready after two-beat read", ready, 0);
    chk(proto_err === exp_err, "R8", "proto_err", proto_err, exp_err);
    if (init_done && !ready && !prev_gap) saw_stall = 1;
    if (q_due.size() > 0 && q_due[0] == cyc) begin
      chk(rdata_valid === 1'b1, q_tag[0], "rdata_valid", rdata_valid, 1);
      chk(rdata === q_dat[0], q_tag[0], "rdata", rdata, q_dat[0]);
      void'(q_due.pop_front()); void'(q_dat.pop_front()); void'(q_tag.pop_front());
    end else begin
      chk(rdata_valid === 1'b0, "R5", "unexpected rdata_valid", rdata_valid, 0);
    end
    exp_err = init_done && rd_req && wr_req;
    prev_gap = 0;
    if (init_done && ready && wr_req && !rd_req) begin
      if (m_open) begin
        merge(m_next);
        m_open = 0;
      end else if (burst_begin) begin
        merge(addr);
        if (size == 2'd2) begin
          m_open = 1;
          m_next = addr + ADDR_W'(1);
        end
      end
    end
    if (init_done && ready && rd_req && !wr_req && !m_open) begin
      q_due.push_back(cyc + RD_LAT); q_dat.push_back(mm[addr]); q_tag.push_back(cur_tag);
      if (size == 2'd2) begin
        q_due.push_back(cyc + RD_LAT + 1);
        q_dat.push_back(mm[addr + ADDR_W'(1)]);
        q_tag.push_back(cur_tag);
        prev_gap = 1;
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_acc();
    do @(negedge clk); while (!ready);
    step();
  endtask

  task automatic wr_burst(logic [ADDR_W-1:0] a, bit two, logic [WORD_W-1:0] d0, logic [WORD_W-1:0] d1,
                          logic [BE_W-1:0] be0, logic [BE_W-1:0] be1, int gap, bit bad_addr);
    wr_req = 1; burst_begin = 1; addr = a; size = two ? 2'd2 : 2'd1; wdata = d0; be = be0;
    wait_acc();
    if (two) begin
      wr_req = 0; burst_begin = 0;
      for (int g = 0; g < gap; g++) begin
        rd_req = 1; addr = a; size = 2'd1;
        step();
      end
      rd_req = 0;
      wr_req = 1; burst_begin = 0; addr = bad_addr ? a + ADDR_W'(9) : a + ADDR_W'(1);
      wdata = d1; be = be1;
      wait_acc();
    end
    wr_req = 0; burst_begin = 0;
  endtask

  task automatic rd_burst(logic [ADDR_W-1:0] a, bit two, string tag);
    cur_tag = tag;
    rd_req = 1; burst_begin = 1; addr = a; size = two ? 2'd2 : 2'd1;
    wait_acc();
    rd_req = 0; burst_begin = 0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    rst_n = 0; wr_req = 0; rd_req = 0; burst_begin = 0; addr = '0; size = 2'd1;
    wdata = '0; be = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); #2 rst_n = 1;
    // R1: requests before init are ignored (no data, no error flag)
    rd_req = 1; wr_req = 1; burst_begin = 1; addr = 6'd0;
    repeat (4) step();
    wr_req = 0;
    repeat (4) step();
    rd_req = 0; burst_begin = 0;
    while (!init_done) step();
    step();
    // R2: two-beat and one-beat bursts
    wr_burst(6'd0, 1, 32'hA0A0_0001, 32'hA1A1_0002, '1, '1, 0, 0);
    rd_burst(6'd0, 1, "R2");
    wr_burst(6'd2, 0, 32'hB0B0_0003, '0, '1, '1, 0, 0);
    rd_burst(6'd2, 0, "R2");
    // R3 and R9: idle gap with reads in it, bad address on second beat
    wr_burst(6'd4, 1, 32'hC4C4_0004, 32'hC5C5_0005, '1, '1, 3, 1);
    rd_burst(6'd4, 1, "R3");
    rd_burst(6'd13, 0, "R9");
    // R4: byte enables
    wr_burst(6'd10, 0, 32'h1122_3344, '0, '1, '1, 0, 0);
    wr_burst(6'd10, 0, 32'hAABB_CCDD, '0, 4'b0101, '1, 0, 0);
    rd_burst(6'd10, 0, "R4");
    // R10: beat without burst_begin while no burst open
    wr_req = 1; burst_begin = 0; addr = 6'd2; size = 2'd1; wdata = 32'hDEAD_BEEF; be = '1;
    wait_acc();
    wr_req = 0;
    rd_burst(6'd2, 0, "R10");
    // R8: simultaneous read and write
    wr_req = 1; rd_req = 1; burst_begin = 1; addr = 6'd0; size = 2'd1; wdata = 32'h5555_5555;
    step();
    wr_req = 0; rd_req = 0; burst_begin = 0;
    step();
    rd_burst(6'd0, 0, "R8");
    // R7: back-to-back single reads
    for (int i = 0; i < 8; i++) wr_burst(ADDR_W'(20 + i), 0, 32'h7000_0000 + i, '0, '1, '1, 0, 0);
    for (int i = 0; i < 8; i++) rd_burst(ADDR_W'(20 + i), 0, "R7");
    // R3: wrap at the top of the array
    wr_burst(6'd63, 1, 32'hF63F_0063, 32'hF00F_0000, '1, '1, 1, 0);
    rd_burst(6'd63, 1, "R3");
    repeat (RD_LAT + 4) step();
    chk(q_due.size() == 0, "R5", "outstanding reads drained", q_due.size(), 0);
    chk(saw_stall, "R11", "pseudo-random stall seen", saw_stall, 1);
    finished = 1;
    finish_run();
  end
endmodule